// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block decides which clock domains of a small microcontroller core may run. A one-cycle sleep strobe from the instruction decoder is taken only when the sleep-enable bit is set and the 3-bit mode field holds one of four legal low-power codes. While the core sleeps, the block holds five clock-enable outputs low or high as the mode requires. These outputs cover CPU, program flash, I/O, ADC and the asynchronous timer.

Wake requests arrive as a vector of flags. Each mode accepts only its own subset of them. Level-sensitive external lines must be held for a few cycles before the two deep modes accept them. After an interrupt ends a deep mode, the block keeps the clocks gated for a selectable oscillator restart time, then opens them and raises a one-cycle completion flag. A reset request ends any sleep at once. On entry to the two light modes, the block can also fire a one-cycle ADC start strobe.

Top module: `sleep_ctrl`

## Requirements
- R1: A `sleep_pulse` is taken only while the core is awake, with `sleep_en`=1, `rst_req`=0 and `mode_sel` in 0..3. The gated state shows from the next cycle. A pulse with `sleep_en`=0, or with `mode_sel` in 4..7, changes no output.
- R2: Mode 0 (light idle) drives CPU and flash enables low, drives I/O and ADC enables high, and sets the timer enable equal to `async_sel`.
- R3: Mode 1 (ADC quiet) drives CPU, flash and I/O enables low, drives the ADC enable high, and sets the timer enable equal to `async_sel`.
- R4: Mode 2 (deep off) drives all five enables low.
- R5: Mode 3 (deep timer-keep) drives all enables low except the timer enable, which equals `async_sel`.
- R6: The `irq` bits are: 0 ADC done, 1 bus address match, 2 timer overflow, 3 timer compare, 4 memory ready, 5 level line A, 6 level line B, 7 edge line, 8 any other interrupt. Mode 0 accepts all bits. Mode 1 accepts bits 0..7. Mode 2 accepts bits 1, 5, 6 and 7. Mode 3 accepts bits 1, 5, 6 and 7, and also bits 2 and 3 when `async_sel`=1.
- R7: Bit 2 wakes only when `tmr_ie[0]`=1 and `gie`=1. Bit 3 wakes only when `tmr_ie[1]`=1 and `gie`=1.
- R8: In modes 2 and 3, bits 5 and 6 wake the core only after they have been high for 4 consecutive cycles. Any low cycle restarts the count.
- R9: After an interrupt wake from mode 2 or 3, the clocks stay gated for 0, 16, 256 or 1024 cycles, selected by `dly_sel` = 0, 1, 2 or 3. Modes 0 and 1 wake in the cycle after the request.
- R10: `rst_req` during sleep or during the restart wait opens all clocks in the next cycle, and `wake_done` stays low.
- R11: `wake_done` is high for exactly one cycle: the first awake cycle after an interrupt wake.
- R12: `adc_start` pulses for one cycle, in the first sleep cycle, when mode 0 or 1 is entered with `adc_on`=1. Otherwise it stays low.
- R13: While awake, CPU, flash, I/O and ADC enables are high, and the timer enable equals `async_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_pulse | input | 1 | One-cycle sleep strobe |
| sleep_en | input | 1 | Permits sleep entry |
| mode_sel | input | 3 | Low-power mode code |
| async_sel | input | 1 | Timer runs from its own clock |
| adc_on | input | 1 | ADC enabled |
| dly_sel | input | 2 | Restart delay select |
| tmr_ie | input | 2 | Timer overflow/compare interrupt enables |
| gie | input | 1 | Global interrupt enable |
| rst_req | input | 1 | Any reset request |
| irq | input | 9 | Wake request flags (see R6) |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_tmr | output | 1 | Async timer clock enable |
| adc_start | output | 1 | ADC conversion start strobe |
| wake_done | output | 1 | Interrupt wake completed |

## Verification
A corrupted stored mode shows in the first sleep cycle, as a wrong pattern on the five enables, or later as a wake source that is wrongly accepted or refused. A fault in the restart counter moves the CPU-enable rising edge away from its expected cycle, so the bench times that edge to the exact cycle for every delay select. A bad level-filter count lets a 3-cycle level wake the core. That shows on `clk_en_cpu` within one cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int NUM_SRC   = 9;
    localparam int SRC_ADC   = 0;
    localparam int SRC_ADDR  = 1;
    localparam int SRC_TOVF  = 2;
    localparam int SRC_TCMP  = 3;
    localparam int SRC_MEM   = 4;
    localparam int SRC_LVL0  = 5;
    localparam int SRC_LVL1  = 6;
    localparam int SRC_EDGE  = 7;
    localparam int SRC_OTHER = 8;

    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_ADCQ  = 3'd1,
        M_PDOWN = 3'd2,
        M_PSAVE = 3'd3
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_AWAKE   = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_RESTART = 2'd2
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic tmr;
    } clk_en_t;

    function automatic logic is_deep(slp_mode_e m);
        return (m == M_PDOWN) || (m == M_PSAVE);
    endfunction

    function automatic clk_en_t clk_map(logic awake, slp_mode_e m, logic asel);
        clk_en_t c;
        c = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, tmr: asel};
        if (awake) begin
            c.cpu   = 1'b1;
            c.flash = 1'b1;
            c.io    = 1'b1;
            c.adc   = 1'b1;
        end else begin
            case (m)
                M_IDLE:  begin c.io = 1'b1; c.adc = 1'b1; end
                M_ADCQ:  c.adc = 1'b1;
                M_PDOWN: c.tmr = 1'b0;
                default: ;
            endcase
        end
        return c;
    endfunction

    function automatic logic [NUM_SRC-1:0] wake_mask(slp_mode_e m, logic asel);
        logic [NUM_SRC-1:0] deep_set;
        logic [NUM_SRC-1:0] mk;
        deep_set = '0;
        deep_set[SRC_ADDR] = 1'b1;
        deep_set[SRC_LVL0] = 1'b1;
        deep_set[SRC_LVL1] = 1'b1;
        deep_set[SRC_EDGE] = 1'b1;
        case (m)
            M_IDLE: mk = '1;
            M_ADCQ: begin
                mk = '1;
                mk[SRC_OTHER] = 1'b0;
            end
            M_PDOWN: mk = deep_set;
            default: begin
                mk = deep_set;
                mk[SRC_TOVF] = asel;
                mk[SRC_TCMP] = asel;
            end
        endcase
        return mk;
    endfunction

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  slp_mode_e          mode,
    input  logic [NUM_SRC-1:0] irq,
    input  logic               async_sel,
    input  logic [1:0]         tmr_ie,
    input  logic               gie,
    output logic               hit
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_CYC - 1);

    logic [NUM_SRC-1:0] qual;
    logic [NUM_SRC-1:0] held_ok;

    always_comb begin
        qual = irq;
        qual[SRC_TOVF] = irq[SRC_TOVF] & tmr_ie[0] & gie;
        qual[SRC_TCMP] = irq[SRC_TCMP] & tmr_ie[1] & gie;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g == SRC_LVL0 || g == SRC_LVL1) begin : g_lvl
            logic [CW-1:0] run;
            always_ff @(posedge clk) begin
                if (rst || !arm || !irq[g]) begin
                    run <= '0;
                end else if (run != FULL) begin
                    run <= run + 1'b1;
                end
            end
            assign held_ok[g] = !is_deep(mode) || (run == FULL);
        end else begin : g_pass
            assign held_ok[g] = 1'b1;
        end
    end

    assign hit = arm && |(qual & wake_mask(mode, async_sel) & held_ok);

endmodule

// File: rtl/slp_restart_cnt.sv
module slp_restart_cnt #(
    parameter int DLY1 = 16,
    parameter int DLY2 = 256,
    parameter int DLY3 = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       zero_len,
    output logic       done
);
    localparam int CW = $clog2(DLY3 + 1);

    logic [CW-1:0] span;
    logic [CW-1:0] cnt;

    always_comb begin
        case (sel)
            2'd1:    span = CW'(DLY1);
            2'd2:    span = CW'(DLY2);
            2'd3:    span = CW'(DLY3);
            default: span = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= span;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero_len = (span == '0);
    assign done     = (cnt == CW'(1));

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import slp_pkg::*;
#(
    parameter int DLY1     = 16,
    parameter int DLY2     = 256,
    parameter int DLY3     = 1024,
    parameter int HOLD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_pulse,
    input  logic               sleep_en,
    input  logic [2:0]         mode_sel,
    input  logic               async_sel,
    input  logic               adc_on,
    input  logic [1:0]         dly_sel,
    input  logic [1:0]         tmr_ie,
    input  logic               gie,
    input  logic               rst_req,
    input  logic [NUM_SRC-1:0] irq,
    output logic               clk_en_cpu,
    output logic               clk_en_flash,
    output logic               clk_en_io,
    output logic               clk_en_adc,
    output logic               clk_en_tmr,
    output logic               adc_start,
    output logic               wake_done
);
    slp_state_e state;
    slp_mode_e  mode_q;
    logic       done_q;
    logic       adc_q;
    logic       entry;
    logic       hit;
    logic       load;
    logic       zero_len;
    logic       cnt_done;
    clk_en_t    ce;

    assign entry = (state == ST_AWAKE) && sleep_pulse && sleep_en
                   && !mode_sel[2] && !rst_req;
    assign load  = (state == ST_SLEEP) && !rst_req && hit && is_deep(mode_q);

    slp_wake_qual #(.HOLD_CYC(HOLD_CYC)) i_qual (
        .clk       (clk),
        .rst       (rst),
        .arm       (state == ST_SLEEP),
        .mode      (mode_q),
        .irq       (irq),
        .async_sel (async_sel),
        .tmr_ie    (tmr_ie),
        .gie       (gie),
        .hit       (hit)
    );

    slp_restart_cnt #(.DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)) i_rcnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .sel      (dly_sel),
        .zero_len (zero_len),
        .done     (cnt_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_AWAKE;
            mode_q <= M_IDLE;
            done_q <= 1'b0;
            adc_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            adc_q  <= 1'b0;
            case (state)
                ST_AWAKE: begin
                    if (entry) begin
                        state  <= ST_SLEEP;
                        mode_q <= slp_mode_e'(mode_sel);
                        adc_q  <= adc_on && !mode_sel[1];
                    end
                end
                ST_SLEEP: begin
                    if (rst_req) begin
                        state  <= ST_AWAKE;
                        mode_q <= M_IDLE;
                    end else if (hit) begin
                        if (is_deep(mode_q) && !zero_len) begin
                            state <= ST_RESTART;
                        end else begin
                            state  <= ST_AWAKE;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_RESTART: begin
                    if (rst_req) begin
                        state  <= ST_AWAKE;
                        mode_q <= M_IDLE;
                    end else if (cnt_done) begin
                        state  <= ST_AWAKE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end

    assign ce           = clk_map(state == ST_AWAKE, mode_q, async_sel);
    assign clk_en_cpu   = ce.cpu;
    assign clk_en_flash = ce.flash;
    assign clk_en_io    = ce.io;
    assign clk_en_adc   = ce.adc;
    assign clk_en_tmr   = ce.tmr;
    assign adc_start    = adc_q;
    assign wake_done    = done_q;

endmodule

// File: rtl/slp_checker.sv
module slp_checker (
    input logic       clk,
    input logic       rst,
    input logic       sleep_pulse,
    input logic       sleep_en,
    input logic [2:0] mode_sel,
    input logic       async_sel,
    input logic       rst_req,
    input logic       clk_en_cpu,
    input logic       clk_en_flash,
    input logic       clk_en_io,
    input logic       clk_en_adc,
    input logic       clk_en_tmr,
    input logic       adc_start,
    input logic       wake_done
);
    assert_enter_R1: assert property (@(posedge clk) disable iff (rst)
        sleep_pulse && sleep_en && !mode_sel[2] && clk_en_cpu && !rst_req |=> !clk_en_cpu);

    assert_ignore_R1: assert property (@(posedge clk) disable iff (rst)
        clk_en_cpu && sleep_pulse && (!sleep_en || mode_sel[2]) |=> clk_en_cpu);

    assert_light_R2: assert property (@(posedge clk) disable iff (rst)
        clk_en_io && !clk_en_cpu |-> clk_en_adc && !clk_en_flash);

    assert_deep_R4: assert property (@(posedge clk) disable iff (rst)
        !clk_en_adc |-> !clk_en_io && !clk_en_cpu && !clk_en_flash);

    assert_tmr_sel_R5: assert property (@(posedge clk) disable iff (rst)
        clk_en_tmr |-> async_sel);

    assert_rst_wake_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req && !clk_en_cpu |=> clk_en_cpu && !wake_done);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> !wake_done);

    assert_done_awake_R11: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> clk_en_cpu);

    assert_rise_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en_cpu) |-> wake_done || $past(rst_req));

    assert_adc_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    assert_adc_ctx_R12: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !clk_en_cpu && clk_en_adc);
endmodule

bind sleep_ctrl slp_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_pulse  (sleep_pulse),
    .sleep_en     (sleep_en),
    .mode_sel     (mode_sel),
    .async_sel    (async_sel),
    .rst_req      (rst_req),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_flash (clk_en_flash),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .clk_en_tmr   (clk_en_tmr),
    .adc_start    (adc_start),
    .wake_done    (wake_done)
);

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_pulse = 1'b0;
    logic       sleep_en = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       async_sel = 1'b0;
    logic       adc_on = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic [1:0] tmr_ie = 2'b11;
    logic       gie = 1'b1;
    logic       rst_req = 1'b0;
    logic [8:0] irq = '0;
    logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr;
    logic adc_start, wake_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_ctrl i_sleep_ctrl (
        .clk(clk), .rst(rst), .sleep_pulse(sleep_pulse), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .async_sel(async_sel), .adc_on(adc_on),
        .dly_sel(dly_sel), .tmr_ie(tmr_ie), .gie(gie), .rst_req(rst_req),
        .irq(irq), .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash),
        .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc), .clk_en_tmr(clk_en_tmr),
        .adc_start(adc_start), .wake_done(wake_done)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [4:0] exp_clk(input logic awake, input int m, input logic a);
        if (awake) return {4'b1111, a};
        case (m)
            0: return {4'b0011, a};
            1: return {4'b0001, a};
            2: return 5'b00000;
            default: return {4'b0000, a};
        endcase
    endfunction

    function automatic logic exp_wake(input int m, input int b, input logic a,
                                      input logic [1:0] ie, input logic g);
        logic ok_t;
        logic deep_ok;
        ok_t = (b == 2) ? (ie[0] & g) : (b == 3) ? (ie[1] & g) : 1'b1;
        deep_ok = (b == 1) || (b == 5) || (b == 6) || (b == 7);
        case (m)
            0: return ok_t;
            1: return ok_t && (b != 8);
            2: return deep_ok;
            default: return ok_t && (deep_ok || (a && (b == 2 || b == 3)));
        endcase
    endfunction

    function automatic int dly_len(input int s);
        return (s == 0) ? 0 : (s == 1) ? 16 : (s == 2) ? 256 : 1024;
    endfunction

    task automatic enter(input int m);
        mode_sel = 3'(m);
        sleep_en = 1'b1;
        sleep_pulse = 1'b1;
        step();
        sleep_pulse = 1'b0;
    endtask

    task automatic kick_reset();
        rst_req = 1'b1;
        step();
        rst_req = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R13: reset state is awake
        check({clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr},
              exp_clk(1'b1, 0, 1'b0), "R13 reset clocks");
        check(wake_done, 0, "R11 reset done");
        check(adc_start, 0, "R12 reset adc");

        // R1 R2 R3 R4 R5 R12 R13 R10: entry sweep
        for (int m = 0; m < 8; m++) begin
            for (int en = 0; en < 2; en++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int ad = 0; ad < 2; ad++) begin
                        logic slept;
                        async_sel = a[0];
                        adc_on = ad[0];
                        mode_sel = 3'(m);
                        sleep_en = en[0];
                        sleep_pulse = 1'b1;
                        step();
                        sleep_pulse = 1'b0;
                        slept = en[0] && (m < 4);
                        check({clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr},
                              exp_clk(!slept, m, a[0]), "R1/R2/R3/R4/R5 mode clocks");
                        check(adc_start, int'(slept && m < 2 && ad[0]), "R12 adc start");
                        step();
                        check(adc_start, 0, "R12 adc one cycle");
                        if (slept) begin
                            kick_reset();
                            check({clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_tmr},
                                  exp_clk(1'b1, 0, a[0]), "R10 reset wake clocks");
                            check(wake_done, 0, "R10 no done");
                        end
                    end
                end
            end
        end
        adc_on = 1'b0;

        // R6 R7: source acceptance sweep
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int b = 0; b < 9; b++) begin
                    for (int ie = 0; ie < 4; ie++) begin
                        for (int g = 0; g < 2; g++) begin
                            logic w;
                            if ((b != 2 && b != 3) && (ie != 3 || g != 1)) continue;
                            async_sel = a[0];
                            tmr_ie = 2'(ie);
                            gie = g[0];
                            dly_sel = 2'd0;
                            enter(m);
                            irq = 9'(1 << b);
                            repeat (4) step();
                            irq = '0;
                            w = exp_wake(m, b, a[0], 2'(ie), g[0]);
                            check(clk_en_cpu, int'(w), "R6/R7 wake accept");
                            if (!w) kick_reset();
                        end
                    end
                end
            end
        end
        tmr_ie = 2'b11;
        gie = 1'b1;

        // R8: level hold filter in deep modes
        for (int m = 2; m < 4; m++) begin
            for (int b = 5; b < 7; b++) begin
                dly_sel = 2'd0;
                enter(m);
                irq = 9'(1 << b);
                repeat (3) step();
                irq = '0;
                check(clk_en_cpu, 0, "R8 three cycles rejected");
                step();
                irq = 9'(1 << b);
                repeat (3) step();
                check(clk_en_cpu, 0, "R8 count restarts");
                irq = '0;
                step();
                irq = 9'(1 << b);
                repeat (4) step();
                irq = '0;
                check(clk_en_cpu, 1, "R8 four cycles accepted");
                check(wake_done, 1, "R11 done after level wake");
                step();
            end
        end

        // R9 R11: restart delay timing
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                int n;
                int exp_n;
                dly_sel = 2'(s);
                enter(m);
                irq = 9'(1 << 1);
                step();
                irq = '0;
                n = 0;
                while (!clk_en_cpu && n < 2000) begin
                    step();
                    n++;
                end
                exp_n = (m >= 2) ? dly_len(s) : 0;
                check(n, exp_n, "R9 restart delay");
                check(wake_done, 1, "R11 done on wake");
                step();
                check(wake_done, 0, "R11 done single cycle");
            end
        end

        // R10: reset during restart wait
        begin
            int seen;
            dly_sel = 2'd2;
            enter(2);
            irq = 9'(1 << 7);
            step();
            irq = '0;
            repeat (5) step();
            check(clk_en_cpu, 0, "R9 still waiting");
            kick_reset();
            check(clk_en_cpu, 1, "R10 reset cuts restart");
            seen = 0;
            for (int k = 0; k < 300; k++) begin
                if (wake_done) seen++;
                step();
            end
            check(seen, 0, "R10 no done after reset");
        end

        summary();
        $finish;
    end
endmodule